// File: doc/BRIEF.md
# Quadrature Encoder Timer Counter

This block is a count register with a ceiling and a prescaler. It either advances on every cycle of its own clock or follows a two-phase incremental encoder wired to inputs A and B. A 3-bit mode field picks one of four count sources:

- the clock;
- both edges of A, with B's level giving the sign;
- both edges of B, with A's level giving the sign;
- every edge of both phases (four counts per encoder cycle).

The count runs between zero and a programmable ceiling. It wraps in either direction and gives a one-cycle update pulse on each wrap.

Software programs the block through a small synchronous register port. The port offers an enable bit, a mode field, a read-only direction flag, the ceiling, the prescaler, the live count and an update strobe. The prescaler value is buffered. A new value takes effect only at the next update event, which is a wrap or a write to the strobe. The ceiling and the count take effect as soon as they are written.

Top module: `qenc_timer`

## Requirements
- R1: After reset the count is 0, the ceiling is all ones, the prescaler is 0, enable is 0, the mode is 0, the direction flag is 0 and upd_pulse is low.
- R2: The register map is as follows. Address 0 is control: bit 0 enable, bits 6:4 mode, bit 1 the read-only direction flag, which a write does not alter. Address 1 is the ceiling, address 2 the prescaler, and address 3 the count. Address 4 is the update strobe (act on write data bit 0) and reads as 0. Read data is combinational from reg_addr.
- R3: The count changes from stepping only while enable is 1. Mode values 4 to 7 hold the count even when enabled.
- R4: In mode 0 every enabled clock cycle is one step up, and the encoder inputs have no effect.
- R5: In mode 1 each change of synchronized A is one step: up when the new A differs from B, down otherwise. Changes of B alone give no step.
- R6: In mode 2 each change of synchronized B is one step: up when the new B equals A, down otherwise. Changes of A alone give no step.
- R7: In mode 3 a change of A alone or of B alone is one step, with the sign rules of R5 and R6. If both change in the same sample, no step is taken.
- R8: With an active prescaler value P, one count occurs per P+1 steps. A written prescaler value reads back at once but becomes active only at the next update event.
- R9: A counted up step from a value at or above the ceiling gives 0. A counted down step from 0 gives the ceiling. Each such wrap gives a one-cycle high on upd_pulse.
- R10: The direction flag reads 1 after the latest step was down and 0 after an up step, including every mode-0 step.
- R11: Writing 1 to the strobe sets the count to 0, restarts the prescaler phase, loads the buffered prescaler value and gives one upd_pulse.
- R12: An encoder input change affects the count on the third rising clock edge after it is applied: two synchronizer flops, then the count register.
- R13: A count write loads the written value on its clock edge and takes priority over a step on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Register read data |
| upd_pulse | output | 1 | One cycle high per update event |

## Verification
The bench goes after four kinds of corner case.

- **Wraps.** It wraps down from 0 to the ceiling, wraps up from the ceiling, and counts up from a count written above the ceiling. A design with an off-by-one compare would give the ceiling plus one, or skip the pulse.
- **Double change in mode 3.** It drives A and B together in the four-count mode. A decoder that took this as a step would drift the count.
- **Prescaler buffering.** It writes a new prescaler value without an update event. A design that applied it at once would count too early.
- **Timing and priority.** It probes the input latency one edge at a time, writes the count on an edge that also steps, and sends edges while the block is disabled or in a reserved mode. Each of these shows up as a count off by one.

// File: rtl/qenc_pkg.sv
`timescale 1ns/1ps
package qenc_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CEIL   = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_PSC    = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_CNT    = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_STROBE = 3'd4;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_DIR_BIT  = 1;
    localparam int CTRL_MODE_LSB = 4;
    localparam int MODE_W        = 3;

    localparam logic [MODE_W-1:0] MODE_CLK   = 3'd0;
    localparam logic [MODE_W-1:0] MODE_EDG_A = 3'd1;
    localparam logic [MODE_W-1:0] MODE_EDG_B = 3'd2;
    localparam logic [MODE_W-1:0] MODE_EDG_X = 3'd3;
endpackage

// File: rtl/qenc_input_sync.sv
`timescale 1ns/1ps
module qenc_input_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic sync_o,
    output logic prev_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], din};
        s_d.prev  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_o = s_q.chain[STAGES-1];
    assign prev_o = s_q.prev;
endmodule

// File: rtl/qenc_step_decode.sv
`timescale 1ns/1ps
module qenc_step_decode
    import qenc_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    input  logic              a_now,
    input  logic              a_prev,
    input  logic              b_now,
    input  logic              b_prev,
    output logic              step_o,
    output logic              up_o
);
    logic a_edge, b_edge, a_sign, b_sign;

    always_comb begin
        a_edge = a_now ^ a_prev;
        b_edge = b_now ^ b_prev;
        a_sign = a_now ^ b_now;      // A moved: up when the phases now differ
        b_sign = ~(a_now ^ b_now);   // B moved: up when the phases now match
        step_o = 1'b0;
        up_o   = 1'b1;
        case (mode_i)
            MODE_CLK: begin
                step_o = 1'b1;
                up_o   = 1'b1;
            end
            MODE_EDG_A: begin
                step_o = a_edge;
                up_o   = a_sign;
            end
            MODE_EDG_B: begin
                step_o = b_edge;
                up_o   = b_sign;
            end
            MODE_EDG_X: begin
                step_o = a_edge ^ b_edge;
                up_o   = a_edge ? a_sign : b_sign;
            end
            default: begin
                step_o = 1'b0;
                up_o   = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/qenc_prescaler.sv
`timescale 1ns/1ps
module qenc_prescaler #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             clear_i,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] psc_new_i,
    output logic             ce_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] phase;
        logic [CNT_W-1:0] active;
    } psc_t;

    psc_t s_d, s_q;

    assign ce_o = tick_i && (s_q.phase >= s_q.active);

    always_comb begin
        s_d = s_q;
        if (clear_i)     s_d.phase = '0;
        else if (ce_o)   s_d.phase = '0;
        else if (tick_i) s_d.phase = s_q.phase + ONE;
        if (reload_i)    s_d.active = psc_new_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R8: the phase never runs past the active division value
    a_r8_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.phase <= s_q.active);
endmodule

// File: rtl/qenc_count_core.sv
`timescale 1ns/1ps
module qenc_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_i,
    input  logic             tick_i,
    input  logic             up_i,
    input  logic [CNT_W-1:0] ceil_i,
    input  logic             wr_cnt_i,
    input  logic [CNT_W-1:0] wr_val_i,
    input  logic             strobe_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             dir_o,
    output logic             upd_o,
    output logic             upd_now_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dir;
        logic             upd;
    } core_t;

    core_t s_d, s_q;
    logic  wrap;

    always_comb begin
        s_d     = s_q;
        s_d.upd = 1'b0;
        wrap    = 1'b0;
        if (tick_i) s_d.dir = ~up_i;
        if (strobe_i) begin
            s_d.cnt = '0;
        end else if (wr_cnt_i) begin
            s_d.cnt = wr_val_i;
        end else if (ce_i) begin
            if (up_i) begin
                if (s_q.cnt >= ceil_i) begin
                    s_d.cnt = '0;
                    wrap    = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + ONE;
                end
            end else begin
                if (s_q.cnt == '0) begin
                    s_d.cnt = ceil_i;
                    wrap    = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - ONE;
                end
            end
        end
        upd_now_o = strobe_i | wrap;
        s_d.upd   = upd_now_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;
    assign dir_o = s_q.dir;
    assign upd_o = s_q.upd;

    // R3: without a counted step, write or strobe the count stays put
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_i && !wr_cnt_i && !strobe_i) |=> $stable(s_q.cnt));

    // R9: counted up step at or beyond the ceiling lands on zero with a pulse
    a_r9_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_i && up_i && (s_q.cnt >= ceil_i) && !wr_cnt_i && !strobe_i)
        |=> (s_q.cnt == '0) && s_q.upd);

    // R9: counted down step from zero lands on the ceiling with a pulse
    a_r9_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_i && !up_i && (s_q.cnt == '0) && !wr_cnt_i && !strobe_i)
        |=> (s_q.cnt == $past(ceil_i)) && s_q.upd);

    // R11: strobe clears the count and pulses the update output
    a_r11_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> (s_q.cnt == '0) && s_q.upd);
endmodule

// File: rtl/qenc_timer.sv
`timescale 1ns/1ps
module qenc_timer
    import qenc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_a,
    input  logic              enc_b,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              upd_pulse
);
    localparam int NPH = 2;  // phase index 0 = A, 1 = B

    typedef struct packed {
        logic              en;
        logic [MODE_W-1:0] mode;
        logic [CNT_W-1:0]  ceil;
        logic [CNT_W-1:0]  psc;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [NPH-1:0]   enc_in, ph_now, ph_prev;
    logic             step, step_up, tick, ce;
    logic             wr_cnt, strobe, upd_now;
    logic [CNT_W-1:0] cnt;
    logic             dir;

    assign enc_in = {enc_b, enc_a};

    generate
        for (genvar g = 0; g < NPH; g++) begin : g_phase
            qenc_input_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (enc_in[g]),
                .sync_o(ph_now[g]),
                .prev_o(ph_prev[g])
            );
        end
    endgenerate

    qenc_step_decode u_dec (
        .mode_i(cfg_q.mode),
        .a_now (ph_now[0]),
        .a_prev(ph_prev[0]),
        .b_now (ph_now[1]),
        .b_prev(ph_prev[1]),
        .step_o(step),
        .up_o  (step_up)
    );

    assign tick   = cfg_q.en & step;
    assign wr_cnt = reg_we && (reg_addr == ADR_CNT);
    assign strobe = reg_we && (reg_addr == ADR_STROBE) && reg_wdata[0];

    qenc_prescaler #(.CNT_W(CNT_W)) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .clear_i  (strobe),
        .reload_i (upd_now),
        .psc_new_i(cfg_q.psc),
        .ce_o     (ce)
    );

    qenc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_i     (ce),
        .tick_i   (tick),
        .up_i     (step_up),
        .ceil_i   (cfg_q.ceil),
        .wr_cnt_i (wr_cnt),
        .wr_val_i (reg_wdata),
        .strobe_i (strobe),
        .cnt_o    (cnt),
        .dir_o    (dir),
        .upd_o    (upd_pulse),
        .upd_now_o(upd_now)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (reg_we) begin
            case (reg_addr)
                ADR_CTRL: begin
                    cfg_d.en   = reg_wdata[CTRL_EN_BIT];
                    cfg_d.mode = reg_wdata[CTRL_MODE_LSB +: MODE_W];
                end
                ADR_CEIL: cfg_d.ceil = reg_wdata;
                ADR_PSC:  cfg_d.psc  = reg_wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            cfg_q.ceil <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_CTRL: begin
                reg_rdata[CTRL_EN_BIT]                = cfg_q.en;
                reg_rdata[CTRL_DIR_BIT]               = dir;
                reg_rdata[CTRL_MODE_LSB +: MODE_W]    = cfg_q.mode;
            end
            ADR_CEIL: reg_rdata = cfg_q.ceil;
            ADR_PSC:  reg_rdata = cfg_q.psc;
            ADR_CNT:  reg_rdata = cnt;
            default:  reg_rdata = '0;
        endcase
    end

    // R7: a simultaneous change of both phases in the four-count mode is no step
    a_r7_double_change: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_q.mode == MODE_EDG_X) && (ph_now[0] != ph_prev[0]) &&
         (ph_now[1] != ph_prev[1])) |-> !step);

    // R3: while disabled, the direction flag does not move
    a_r3_dir_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.en |=> $stable(dir));
endmodule

// File: tb/sim_qenc_timer.sv
`timescale 1ns/1ps
module sim_qenc_timer;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enc_a = 1'b0;
    logic         enc_b = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic         reg_we = 1'b0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic         upd_pulse;

    always #2.5 clk = ~clk;

    qenc_timer #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .upd_pulse(upd_pulse)
    );

    int checks = 0, fails = 0, upd_seen = 0;
    int m_cnt = 0, m_ceil = 65535, m_preg = 0, m_pact = 0, m_pcnt = 0;
    int m_dir = 0, m_upd = 0, m_en = 0, m_mode = 0;
    int a_lvl = 0, b_lvl = 0;
    int v;

    always @(negedge clk) if (rst_n && upd_pulse) upd_seen++;

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic m_tick(input int up);
        m_dir = up ? 0 : 1;
        if (m_pcnt >= m_pact) begin
            m_pcnt = 0;
            if (up) begin
                if (m_cnt >= m_ceil) begin m_cnt = 0; m_upd++; m_pact = m_preg; end
                else m_cnt++;
            end else begin
                if (m_cnt == 0) begin m_cnt = m_ceil; m_upd++; m_pact = m_preg; end
                else m_cnt--;
            end
        end else begin
            m_pcnt++;
        end
    endtask

    task automatic wr(input int a, input int d);
        reg_addr  = a[2:0];
        reg_wdata = d[W-1:0];
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        case (a)
            0: begin m_en = d & 1; m_mode = (d >> 4) & 7; end
            1: m_ceil = d;
            2: m_preg = d;
            3: m_cnt = d;
            4: if (d & 1) begin m_cnt = 0; m_pcnt = 0; m_pact = m_preg; m_upd++; end
            default: ;
        endcase
    endtask

    task automatic rd(input int a, output int val);
        reg_addr = a[2:0];
        #1;
        val = int'(reg_rdata);
    endtask

    task automatic enc_set(input int na, input int nb);
        bit ae, be;
        ae = (na != a_lvl);
        be = (nb != b_lvl);
        if (m_en == 1) begin
            case (m_mode)
                1: if (ae) m_tick(na != nb);
                2: if (be) m_tick(nb == na);
                3: if (ae ^ be) m_tick(ae ? (na != nb) : (nb == na));
                default: ;
            endcase
        end
        a_lvl = na; b_lvl = nb;
        enc_a = na[0]; enc_b = nb[0];
        repeat (4) @(negedge clk);
    endtask

    task automatic chk_state(input string req);
        int c, d;
        rd(3, c);
        chk({req, " count"}, c, m_cnt);
        rd(0, d);
        chk({req, " dir"}, (d >> 1) & 1, m_dir);
        chk({req, " upd pulses"}, upd_seen, m_upd);
    endtask

    // enabled mode-0 window of k clock ticks
    task automatic clk_window(input int k);
        wr(0, 32'h01);
        for (int i = 0; i < k - 1; i++) begin
            if (i == 1) begin enc_a = ~enc_a; a_lvl = 1 - a_lvl; end  // R4 inputs ignored
            @(negedge clk);
        end
        for (int i = 0; i < k; i++) m_tick(1);
        wr(0, 32'h00);
        repeat (4) @(negedge clk);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1-R13 run hung actual=1 expected=0");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, v); chk("R1 ctrl", v, 0);
        rd(1, v); chk("R1 ceiling", v, 65535);
        rd(2, v); chk("R1 prescaler", v, 0);
        rd(3, v); chk("R1 count", v, 0);
        chk("R1 upd_pulse", int'(upd_pulse), 0);
        rd(4, v); chk("R2 strobe reads zero", v, 0);

        // R2 direction flag is read-only
        wr(0, 32'h02);
        rd(0, v); chk("R2 ctrl dir bit ignored", v, 0);

        // R4 mode 0 counting with wrap at ceiling 4
        wr(1, 4); wr(2, 0); wr(4, 1);
        clk_window(7);
        chk_state("R4");

        // R8 prescaler readback and division
        wr(2, 2);
        rd(2, v); chk("R8 prescaler readback", v, 2);
        wr(4, 1);
        clk_window(10);
        chk_state("R8 divide");

        // R8 new value not active until an update event
        wr(2, 0);
        clk_window(3);
        chk_state("R8 buffered");
        wr(4, 1);
        repeat (2) @(negedge clk);
        chk_state("R11 strobe");

        // R13 count write overrides a step on the same edge
        wr(0, 32'h01);
        wr(3, 3);
        m_tick(1);
        wr(0, 32'h00);
        repeat (2) @(negedge clk);
        chk_state("R13");

        // R12 latency, mode 1
        wr(1, 100); wr(3, 50);
        enc_set(0, 0);
        wr(0, 32'h11);
        enc_a = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(3, v); chk("R12 no change after two edges", v, 50);
        @(negedge clk);
        rd(3, v); chk("R12 change on third edge", v, 51);
        m_tick(1); a_lvl = 1;
        repeat (2) @(negedge clk);

        // R5 mode 1
        enc_set(1, 1); chk_state("R5 B ignored");
        enc_set(0, 1); chk_state("R5 A edge up");
        enc_set(0, 0); chk_state("R5 B ignored");
        enc_set(1, 0); chk_state("R5 A edge up");
        enc_set(0, 0); chk_state("R5 A edge down");

        // R6 mode 2
        wr(0, 32'h21);
        enc_set(1, 0); chk_state("R6 A ignored");
        enc_set(1, 1); chk_state("R6 B edge up");
        enc_set(1, 0); chk_state("R6 B edge down");
        enc_set(0, 0); chk_state("R6 A ignored");
        enc_set(0, 1); chk_state("R6 B edge down");

        // R7 mode 3 full cycles and double changes
        wr(0, 32'h31);
        enc_set(0, 0);
        enc_set(1, 0); chk_state("R7 up");
        enc_set(1, 1); chk_state("R7 up");
        enc_set(0, 1); chk_state("R7 up");
        enc_set(0, 0); chk_state("R7 up");
        enc_set(0, 1); chk_state("R10 down");
        enc_set(1, 1); chk_state("R10 down");
        enc_set(0, 0); chk_state("R7 double change");
        enc_set(1, 1); chk_state("R7 double change");

        // R9 wraps
        wr(1, 10); wr(3, 1);
        enc_set(1, 0); chk_state("R9 down to zero");
        enc_set(0, 0); chk_state("R9 wrap down");
        enc_set(1, 0); chk_state("R9 wrap up");
        wr(1, 5); wr(3, 9);
        enc_set(1, 1); chk_state("R9 above ceiling");

        // R3 disabled and reserved mode
        wr(0, 32'h30);
        enc_set(0, 1); chk_state("R3 disabled");
        enc_set(0, 0); chk_state("R3 disabled");
        wr(0, 32'h51);
        enc_set(1, 0); chk_state("R3 reserved mode");
        enc_set(1, 1); chk_state("R3 reserved mode");

        // R11 strobe restarts prescaler phase and loads it
        wr(0, 32'h31); wr(2, 3); wr(3, 2);
        enc_set(0, 1);
        wr(4, 1);
        repeat (2) @(negedge clk);
        chk_state("R11 strobe clears");
        enc_set(0, 0); enc_set(1, 0); enc_set(1, 1);
        chk_state("R11 phase restarted");
        enc_set(0, 1); chk_state("R11 first count");

        // random walks across the encoder modes
        void'($urandom(32'd4242));
        for (int r = 0; r < 40; r++) begin
            int md, ps, cl;
            md = 1 + ($urandom % 3);
            ps = $urandom % 4;
            cl = 3 + ($urandom % 18);
            wr(0, 32'h00);
            wr(1, cl); wr(2, ps); wr(4, 1);
            wr(3, $urandom % (cl + 1));
            wr(0, (md << 4) | 1);
            for (int s = 0; s < 25; s++) begin
                int sel, na, nb;
                sel = $urandom % 8;
                na = a_lvl; nb = b_lvl;
                if (sel == 0) begin na = 1 - na; nb = 1 - nb; end
                else if (sel[0]) na = 1 - na;
                else nb = 1 - nb;
                enc_set(na, nb);
                chk_state("R7 R8 R9 random");
            end
        end

        report();
        $finish;
    end
endmodule